// File: doc/BRIEF.md
# Chien Search Error Locator

This block finds the bit positions of errors in a BCH-protected sector, given the error locator polynomial sigma(x) that a solver has already computed. A host writes the sigma coefficients into a register window, picks the field size (GF(2^13) for a 512-byte sector, GF(2^14) for a 1024-byte sector), then writes the scan length to start a search. The scan length is the number of data bits plus parity bits.

The engine tests one candidate position per clock cycle. Each coefficient has its own register, which is multiplied by a fixed power of the primitive element after every step. A position is a root when the XOR of all coefficient registers is zero. Each root position is stored as a 1-based bit index, in ascending order, in a result array. When the scan ends, a done flag is raised together with the root count. If the root count differs from the sigma degree, the host treats the sector as uncorrectable.

Top module: `chien_locator`

## Requirements
- R1: Writing a length L > 0 to offset 0x08 starts a scan of positions p = 1..L. Position p is a root when the sum over k ≤ D of s_k·α^(p·k) is zero. α is a root of x^13+x^4+x^3+x+1 when config bit 0 is 0, and of x^14+x^10+x^6+x+1 when config bit 0 is 1.
- R2: Coefficient s_k (k = 0..24) is written at offset 0x40+4k, and only its low m bits are used. The degree D is taken from config (offset 0x04) bits 20:16. Coefficient registers with k > D have no effect on the result.
- R3: The status word at offset 0x0C carries done in bit 0 and the root count in bits 12:8. Roots lying outside 1..L are not counted, so the count can fall short of D.
- R4: Entry i of the result array, at offset 0x100+4i, holds the 1-based position of the i-th root found, in increasing position order. Entries at or beyond the root count read as zero.
- R5: The root count saturates at 24, and only the first 24 roots are stored.
- R6: A read of the status word returns the current done value and then clears done. The root count is kept.
- R7: An enable write that arrives while a scan is running is ignored.
- R8: Writing 1 in bit 0 of offset 0x00 stops a running scan and clears both done and the root count.
- R9: An enable write with L = 0 raises done on the next cycle with a root count of zero.
- R10: After reset the engine is idle, the status word reads 0 and all result entries read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid the cycle after |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
Sigma is built in the bench as the product of (x + α^r) over chosen root positions, in both fields. The root sets include positions at the first and last bit of the window, which tells apart an off-by-one in the start or end of the scan. One set places a root beyond the window, so the count must fall below the degree. A degree-zero polynomial has no roots, and an all-zero polynomial makes every position a root and so exercises the 24-entry limit. Because the same root positions yield different coefficients in the two fields, running both fields shows whether the field-select bit actually changes the multiplier feedback.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int M_MAX = 14;
  // feedback terms below the top bit of each primitive polynomial
  localparam logic [M_MAX-1:0] FB_M13 = 14'h001B;
  localparam logic [M_MAX-1:0] FB_M14 = 14'h0443;

  localparam int OFF_STOP = 'h000;
  localparam int OFF_CFG  = 'h004;
  localparam int OFF_GO   = 'h008;
  localparam int OFF_STAT = 'h00C;
  localparam int OFF_SIG  = 'h040;
  localparam int OFF_LOC  = 'h100;

  // multiply by alpha^k in GF(2^13) (wide=0) or GF(2^14) (wide=1)
  function automatic logic [M_MAX-1:0] mul_apow(input logic [M_MAX-1:0] v_in,
                                                input int k, input logic wide);
    logic [M_MAX-1:0] v;
    logic fb;
    v = v_in;
    for (int i = 0; i < k; i++) begin
      fb = wide ? v[M_MAX-1] : v[M_MAX-2];
      v  = {v[M_MAX-2:0], 1'b0};
      if (!wide) v[M_MAX-1] = 1'b0;
      if (fb) v = v ^ (wide ? FB_M14 : FB_M13);
    end
    return v;
  endfunction
endpackage

// File: rtl/cl_term.sv
module cl_term
  import chien_pkg::*;
#(
  parameter int K = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             wide,
  input  logic [M_MAX-1:0] seed,
  output logic [M_MAX-1:0] val_q
);
  logic [M_MAX-1:0] src;
  logic [M_MAX-1:0] nxt;

  always_comb begin
    src = load ? seed : val_q;
    if (!wide) src[M_MAX-1] = 1'b0;
    nxt = mul_apow(src, K, wide);
  end

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else if (load || step) val_q <= nxt;
  end
endmodule

// File: rtl/cl_locmem.sv
module cl_locmem #(
  parameter int DEPTH = 24,
  parameter int W     = 16,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/chien_locator.sv
module chien_locator
  import chien_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 16,
  parameter int T_MAX  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int NCOEF = T_MAX + 1;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic             wide_q;
  logic [CNT_W-1:0] deg_q;
  logic [M_MAX-1:0] sigma_q [NCOEF];
  logic [M_MAX-1:0] seed    [NCOEF];
  logic [M_MAX-1:0] term_v  [NCOEF];
  logic [LEN_W-1:0] len_q, pos_q;
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      rdata_q;
  logic             loc_sel_q, loc_ok_q;
  logic [LEN_W-1:0] mem_q;

  // address decode
  logic [ADDR_W-1:0] sig_off, loc_off;
  logic              sig_hit, loc_hit;
  logic [CNT_W-1:0]  sig_idx, loc_idx;
  logic              wr_stop, wr_cfg, wr_go, rd_stat;

  assign sig_off = bus_addr - ADDR_W'(OFF_SIG);
  assign loc_off = bus_addr - ADDR_W'(OFF_LOC);
  assign sig_hit = (bus_addr >= ADDR_W'(OFF_SIG)) && (sig_off[1:0] == 2'b00) &&
                   ((sig_off >> 2) < ADDR_W'(NCOEF));
  assign loc_hit = (bus_addr >= ADDR_W'(OFF_LOC)) && (loc_off[1:0] == 2'b00) &&
                   ((loc_off >> 2) < ADDR_W'(T_MAX));
  assign sig_idx = sig_off[2 +: CNT_W];
  assign loc_idx = loc_off[2 +: CNT_W];
  assign wr_stop = bus_wr && (bus_addr == ADDR_W'(OFF_STOP)) && bus_wdata[0];
  assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_go   = bus_wr && (bus_addr == ADDR_W'(OFF_GO));
  assign rd_stat = bus_rd && (bus_addr == ADDR_W'(OFF_STAT));

  // search control
  logic [LEN_W-1:0] len_in;
  logic             start, start_run, start_zero, last, hit, store;
  logic [M_MAX-1:0] acc;

  assign len_in     = bus_wdata[LEN_W-1:0];
  assign start      = wr_go && !busy_q;
  assign start_run  = start && (len_in != '0);
  assign start_zero = start && (len_in == '0);
  assign last       = busy_q && (pos_q == len_q);
  assign hit        = busy_q && (acc == '0);
  assign store      = hit && (cnt_q < CNT_W'(T_MAX));

  always_comb begin
    acc = '0;
    for (int k = 0; k < NCOEF; k++) acc = acc ^ term_v[k];
  end

  // one evaluator register per coefficient
  for (genvar g = 0; g < NCOEF; g++) begin : g_term
    assign seed[g] = (CNT_W'(g) <= deg_q) ? sigma_q[g] : '0;
    cl_term #(.K(g)) u_term (
      .clk  (clk),
      .rst  (rst),
      .load (start_run),
      .step (busy_q && !wr_stop),
      .wide (wide_q),
      .seed (seed[g]),
      .val_q(term_v[g])
    );
  end

  cl_locmem #(.DEPTH(T_MAX), .W(LEN_W), .AW(CNT_W)) u_locmem (
    .clk    (clk),
    .we     (store),
    .waddr  (cnt_q),
    .wdata  (pos_q),
    .raddr  (loc_idx),
    .rdata_q(mem_q)
  );

  // configuration and coefficient registers
  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b0;
      deg_q  <= '0;
      for (int k = 0; k < NCOEF; k++) sigma_q[k] <= '0;
    end else begin
      if (wr_cfg) begin
        wide_q <= bus_wdata[0];
        deg_q  <= bus_wdata[16 +: CNT_W];
      end
      for (int k = 0; k < NCOEF; k++)
        if (bus_wr && sig_hit && (sig_idx == CNT_W'(k))) sigma_q[k] <= bus_wdata[M_MAX-1:0];
    end
  end

  // scan state
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      pos_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start) len_q <= len_in;
      if (wr_stop) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
        cnt_q  <= '0;
        pos_q  <= '0;
      end else if (start_run) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt_q  <= '0;
        pos_q  <= LEN_W'(1);
      end else if (start_zero) begin
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        pos_q <= pos_q + LEN_W'(1);
        if (store) cnt_q <= cnt_q + CNT_W'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (rd_stat) begin
        done_q <= 1'b0;
      end
    end
  end

  // read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      loc_sel_q <= 1'b0;
      loc_ok_q  <= 1'b0;
    end else if (bus_rd) begin
      loc_sel_q <= loc_hit;
      loc_ok_q  <= loc_hit && (loc_idx < cnt_q);
      rdata_q   <= rd_stat ? 32'({cnt_q, 7'b0, done_q}) : '0;
    end
  end

  assign bus_rdata = loc_sel_q ? (loc_ok_q ? 32'(mem_q) : '0) : rdata_q;

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/chien_locator_chk.sv
module chien_locator_chk
  import chien_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 16,
  parameter int T_MAX  = 24,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              busy_q,
  input logic              done_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [LEN_W-1:0]  pos_q,
  input logic [LEN_W-1:0]  len_q
);
  logic stop_w, go_w, stat_r;
  assign stop_w = bus_wr && (bus_addr == ADDR_W'(OFF_STOP)) && bus_wdata[0];
  assign go_w   = bus_wr && (bus_addr == ADDR_W'(OFF_GO));
  assign stat_r = bus_rd && (bus_addr == ADDR_W'(OFF_STAT));

  AST_POS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (pos_q >= LEN_W'(1)) && (pos_q <= len_q)); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(done_q && busy_q)); // R3
  AST_CNT_RISES: assert property (@(posedge clk) disable iff (rst)
    busy_q && !stop_w |=> cnt_q >= $past(cnt_q)); // R4
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(T_MAX)); // R5
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    stat_r && !busy_q && !bus_wr |=> !done_q); // R6
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy_q && go_w |=> $stable(len_q)); // R7
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_w |=> !busy_q && !done_q && (cnt_q == '0)); // R8
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    go_w && !busy_q && (bus_wdata[LEN_W-1:0] == '0) |=> done_q && !busy_q); // R9
endmodule

bind chien_locator chien_locator_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .T_MAX(T_MAX), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy_q(busy_q), .done_q(done_q), .cnt_q(cnt_q),
  .pos_q(pos_q), .len_q(len_q)
);

// File: tb/test_chien_locator.sv
module test_chien_locator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  chien_locator i_chien_locator (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        wide;
    logic [15:0] len;
    logic [2:0]  nr;
    logic [15:0] r0, r1, r2, r3;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd200, 3'd3, 16'd5,  16'd77,  16'd199, 16'd0},
    '{1'b0, 16'd300, 3'd2, 16'd1,  16'd300, 16'd0,   16'd0},
    '{1'b1, 16'd400, 3'd4, 16'd3,  16'd150, 16'd260, 16'd399},
    '{1'b1, 16'd100, 3'd0, 16'd0,  16'd0,   16'd0,   16'd0},
    '{1'b0, 16'd150, 3'd2, 16'd50, 16'd180, 16'd0,   16'd0},
    '{1'b1, 16'd500, 3'd3, 16'd2,  16'd256, 16'd500, 16'd0}
  };

  int sig [25];

  function automatic int gmul(int a, int b, bit wide);
    int r = 0;
    int m = wide ? 14 : 13;
    int poly = wide ? 'h4443 : 'h201B;
    for (int i = 0; i < m; i++) begin
      if ((b >> i) & 1) r = r ^ a;
      a = a << 1;
      if ((a >> m) & 1) a = a ^ poly;
    end
    return r;
  endfunction

  function automatic int apow(int j, bit wide);
    int r = 1;
    for (int i = 0; i < j; i++) r = gmul(r, 2, wide);
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 9'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(output int st);
    st = 0;
    for (int t = 0; t < 20000; t++) begin
      bus_read('h0C, st);
      if (st & 1) return;
    end
    check("R3 done timeout", st & 1, 1);
  endtask

  // sigma = product of (x + alpha^r)
  task automatic build_sigma(int roots [4], int n, bit wide);
    for (int k = 0; k < 25; k++) sig[k] = 0;
    sig[0] = 1;
    for (int i = 0; i < n; i++) begin
      int a = apow(roots[i], wide);
      for (int k = n; k >= 1; k--) sig[k] = sig[k-1] ^ gmul(a, sig[k], wide);
      sig[0] = gmul(a, sig[0], wide);
    end
  endtask

  task automatic load_sigma(int deg, bit wide);
    bus_write('h04, (deg << 16) | int'(wide));
    for (int k = 0; k <= deg; k++) bus_write('h40 + 4 * k, sig[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int st, d;
    int roots [4];
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    bus_read('h0C, st);  check("R10 status", st, 0);
    bus_read('h100, d);  check("R10 loc0", d, 0);
    bus_read('h15C, d);  check("R10 loc23", d, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int n, nexp;
      int exp_loc [4];
      roots[0] = VECS[v].r0; roots[1] = VECS[v].r1;
      roots[2] = VECS[v].r2; roots[3] = VECS[v].r3;
      n = VECS[v].nr;
      build_sigma(roots, n, VECS[v].wide);
      load_sigma(n, VECS[v].wide);
      nexp = 0;
      for (int i = 0; i < n; i++)
        if (roots[i] <= int'(VECS[v].len)) begin exp_loc[nexp] = roots[i]; nexp++; end
      bus_write('h08, VECS[v].len);
      wait_done(st);
      check("R3 root count", (st >> 8) & 'h1F, nexp);
      for (int i = 0; i < nexp; i++) begin
        bus_read('h100 + 4 * i, d);
        check("R1 R4 location", d, exp_loc[i]);
      end
      bus_read('h100 + 4 * nexp, d);
      check("R4 unused entry", d, 0);
      if (v == 0) begin
        bus_read('h0C, st);
        check("R6 done cleared", st & 1, 0);
        check("R6 count kept", (st >> 8) & 'h1F, 3);
      end
    end

    // R2 coefficient above degree ignored
    roots[0] = 33;
    build_sigma(roots, 1, 1'b0);
    bus_write('h40 + 4 * 2, 'h1234);
    load_sigma(1, 1'b0);
    bus_write('h08, 120);
    wait_done(st);
    check("R2 count", (st >> 8) & 'h1F, 1);
    bus_read('h100, d);
    check("R2 location", d, 33);

    // R5 saturation: zero polynomial, every position is a root
    for (int k = 0; k < 25; k++) sig[k] = 0;
    load_sigma(0, 1'b1);
    bus_write('h08, 40);
    wait_done(st);
    check("R5 count", (st >> 8) & 'h1F, 24);
    bus_read('h100, d);  check("R5 loc0", d, 1);
    bus_read('h15C, d);  check("R5 loc23", d, 24);

    // R7 enable while busy ignored
    roots[0] = 10;
    build_sigma(roots, 1, 1'b0);
    load_sigma(1, 1'b0);
    bus_write('h08, 300);
    repeat (20) @(negedge clk);
    bus_write('h08, 5);
    wait_done(st);
    check("R7 count", (st >> 8) & 'h1F, 1);
    bus_read('h100, d);
    check("R7 location", d, 10);

    // R8 stop mid-search
    roots[0] = 250;
    build_sigma(roots, 1, 1'b1);
    load_sigma(1, 1'b1);
    bus_write('h08, 300);
    repeat (20) @(negedge clk);
    bus_write('h00, 1);
    repeat (400) @(negedge clk);
    bus_read('h0C, st);
    check("R8 status after stop", st, 0);
    bus_read('h100, d);
    check("R8 loc0 after stop", d, 0);

    // R9 zero length
    bus_write('h08, 0);
    bus_read('h0C, st);
    check("R9 done", st & 1, 1);
    check("R9 count", (st >> 8) & 'h1F, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule